// File: doc/BRIEF.md
# Transmit/Receive Word Buffer with Threshold Interrupts

This block sits between a processor register port and a serial-bus packet engine. It holds two 32-bit word queues. Software writes outgoing words into one, and the engine drains it through a valid/ready pop port. The engine fills the other through a valid/ready push port, and software drains it by reading a data register. Register reads are combinational on `reg_rdata`, and a read of the receive data register removes the word at the edge that ends the access.

A control register sets a threshold for each queue and starts a flush of either queue. A flush bit reads as 1 while the flush runs and clears itself. A status register gives the free transmit slots and the held receive words.

The interrupt status register has fixed bit positions. Six of its bits are sticky and cleared by writing 1. The two data-request bits are live comparisons of occupancy against the thresholds. An 8-bit enable register gates every bit onto `irq`. A build parameter lets the packet-complete bit reach `irq` even when its enable is off.

Top module: `xfer_fifo_ctrl`

## Requirements
- R1: After reset both queues are empty and `irq` is low. The status register (0x60) reads 0x80, the control register (0x5C) reads 0, the enable register (0x64) reads 0, the interrupt status register (0x68) reads 0x02, and `eng_tx_valid` is low.
- R2: Words written to 0x50 appear on `eng_tx_data` in write order. `eng_tx_valid` is high while the queue is not empty. A word leaves at a clock edge where valid and `eng_tx_ready` are both high. Status bits 7:4 give DEPTH minus the number of words held.
- R3: A write to 0x50 while DEPTH words are held sets interrupt status bit 5. The word is discarded and the held words are unchanged.
- R4: `eng_rx_ready` is high while fewer than DEPTH words are held and no receive flush runs. Words pushed by the engine are returned by reads of 0x54 in push order. Status bits 3:0 give the number of receive words held.
- R5: A read of 0x54 while the receive queue is empty returns 0 and sets interrupt status bit 5's neighbour, bit 4.
- R6: A control-register write with bit 1 set flushes the transmit queue, and with bit 0 set flushes the receive queue. The queue is empty from the next edge on. The flush bit reads 1 for exactly two cycles after the write, then reads 0. The thresholds stay at the values written.
- R7: Control bits 7:5 hold the transmit threshold and bits 4:2 the receive threshold. Interrupt status bit 1 is high exactly while free transmit slots exceed the transmit threshold. Bit 0 is high exactly while held receive words exceed the receive threshold.
- R8: A one-cycle pulse on `ev_pkt_done`, `ev_all_done`, `ev_nack` or `ev_arb_lost` sets interrupt status bit 7, 6, 3 or 2 respectively. The bit stays set until software clears it.
- R9: Writing 0x68 clears each sticky bit (7:2) written as 1 and leaves the others. Writing back a value that was read clears exactly the bits that were pending. An event arriving in the same cycle as its clear leaves the bit set.
- R10: `irq` is high exactly while some interrupt status bit and the same enable bit (0x64) are both 1.
- R11: With PKT_IRQ_FORCE set, a pending bit 7 drives `irq` high even when enable bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at 0x54) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| eng_tx_valid | output | 1 | Transmit word available to the engine |
| eng_tx_ready | input | 1 | Engine takes the transmit word |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_rx_valid | input | 1 | Engine offers a received word |
| eng_rx_ready | output | 1 | Receive queue accepts a word |
| eng_rx_data | input | 32 | Received word from the engine |
| ev_pkt_done | input | 1 | Packet finished event |
| ev_all_done | input | 1 | All packets finished event |
| ev_nack | input | 1 | Missing acknowledge event |
| ev_arb_lost | input | 1 | Arbitration lost event |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted pointer or count shows up at the ports at once. The status register reads wrong occupancy on the next access. The data-request bits flip at the wrong fill level in the threshold sweep. Words come out of the wrong slot on the very next pop. A stuck flush sequencer shows up within three cycles as a flush bit that never clears or clears early. A lost sticky bit or a wrong enable is visible on the next status read or directly on `irq`.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
    localparam int REG_AW    = 8;
    localparam int REG_DW    = 32;
    localparam int TRIG_W    = 3;
    localparam int OCC_W     = 4;
    localparam int FLUSH_CYC = 2;

    localparam logic [REG_AW-1:0] A_TXDATA = 8'h50;
    localparam logic [REG_AW-1:0] A_RXDATA = 8'h54;
    localparam logic [REG_AW-1:0] A_FCTRL  = 8'h5C;
    localparam logic [REG_AW-1:0] A_FSTAT  = 8'h60;
    localparam logic [REG_AW-1:0] A_IMASK  = 8'h64;
    localparam logic [REG_AW-1:0] A_ISTAT  = 8'h68;

    // control layout: [7:5] tx threshold, [4:2] rx threshold, [1] tx flush, [0] rx flush
    typedef struct packed {
        logic [TRIG_W-1:0] tx_trig;
        logic [TRIG_W-1:0] rx_trig;
        logic              tx_flush;
        logic              rx_flush;
    } fctrl_t;

    // sticky interrupt bits, packed so that pkt lands on status bit 7 and arb on bit 2
    typedef struct packed {
        logic pkt;
        logic all;
        logic txovf;
        logic rxunf;
        logic nack;
        logic arb;
    } evt_t;

    function automatic logic [REG_DW-1:0] zext8(input logic [7:0] v);
        return {{(REG_DW-8){1'b0}}, v};
    endfunction
endpackage

// File: rtl/xfc_word_fifo.sv
module xfc_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (cnt != CW'(DEPTH));
    assign do_pop  = pop && (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clear) mem[wr_ptr] <= push_data;
    end

    assign head  = mem[rd_ptr];
    assign count = cnt;
endmodule

// File: rtl/xfc_flush_seq.sv
module xfc_flush_seq #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int HW = $clog2(HOLD+1);
    logic [HW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)                left <= '0;
        else if (start)         left <= HW'(HOLD);
        else if (left != '0)    left <= left - 1'b1;
    end

    assign busy = (left != '0);
endmodule

// File: rtl/xfc_irq_regs.sv
module xfc_irq_regs import xfc_pkg::*; #(
    parameter bit PKT_FORCE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  evt_t       ev_set,
    input  logic [1:0] live_req,
    input  logic       clr_we,
    input  evt_t       clr_bits,
    input  logic       mask_we,
    input  logic [7:0] mask_wdata,
    output logic [7:0] status,
    output logic [7:0] mask,
    output logic       irq
);
    evt_t sticky;
    evt_t kept;

    assign kept = clr_we ? evt_t'(sticky & ~clr_bits) : sticky;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky <= '0;
            mask   <= '0;
        end else begin
            sticky <= evt_t'(kept | ev_set);
            if (mask_we) mask <= mask_wdata;
        end
    end

    assign status = {sticky, live_req};
    assign irq    = (|(status & mask)) | (PKT_FORCE & sticky.pkt);
endmodule

// File: rtl/xfer_fifo_ctrl.sv
module xfer_fifo_ctrl import xfc_pkg::*; #(
    parameter int DEPTH         = 8,
    parameter bit PKT_IRQ_FORCE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              eng_tx_valid,
    input  logic              eng_tx_ready,
    output logic [REG_DW-1:0] eng_tx_data,
    input  logic              eng_rx_valid,
    output logic              eng_rx_ready,
    input  logic [REG_DW-1:0] eng_rx_data,
    input  logic              ev_pkt_done,
    input  logic              ev_all_done,
    input  logic              ev_nack,
    input  logic              ev_arb_lost,
    output logic              irq
);
    localparam int CW    = $clog2(DEPTH+1);
    localparam int CMP_W = (CW > TRIG_W) ? CW : TRIG_W;

    fctrl_t            wr_ctl;
    logic [TRIG_W-1:0] tx_trig, rx_trig;
    logic              wr_fctrl, wr_txdata, wr_istat, wr_imask, rd_rxdata;
    logic              tx_flush_go, rx_flush_go, tx_busy, rx_busy, tx_clear, rx_clear;
    logic [CW-1:0]     tx_cnt, rx_cnt, tx_free;
    logic              tx_full, rx_full, tx_push, tx_pop, rx_push, rx_pop;
    logic              tx_ovf, rx_unf, tx_req, rx_req;
    logic [REG_DW-1:0] rx_head;
    logic [7:0]        istat, imask;
    evt_t              ev_set;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_DW-1:8];
    assign wr_ctl       = fctrl_t'(reg_wdata[7:0]);

    assign wr_fctrl  = reg_wr && (reg_addr == A_FCTRL);
    assign wr_txdata = reg_wr && (reg_addr == A_TXDATA);
    assign wr_istat  = reg_wr && (reg_addr == A_ISTAT);
    assign wr_imask  = reg_wr && (reg_addr == A_IMASK);
    assign rd_rxdata = reg_rd && (reg_addr == A_RXDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_trig <= '0;
            rx_trig <= '0;
        end else if (wr_fctrl) begin
            tx_trig <= wr_ctl.tx_trig;
            rx_trig <= wr_ctl.rx_trig;
        end
    end

    assign tx_flush_go = wr_fctrl && wr_ctl.tx_flush;
    assign rx_flush_go = wr_fctrl && wr_ctl.rx_flush;

    xfc_flush_seq #(.HOLD(FLUSH_CYC)) u_tx_flush (
        .clk(clk), .rst(rst), .start(tx_flush_go), .busy(tx_busy)
    );
    xfc_flush_seq #(.HOLD(FLUSH_CYC)) u_rx_flush (
        .clk(clk), .rst(rst), .start(rx_flush_go), .busy(rx_busy)
    );

    assign tx_clear = tx_flush_go || tx_busy;
    assign rx_clear = rx_flush_go || rx_busy;

    // transmit path: software pushes, engine pops
    assign tx_full      = (tx_cnt == CW'(DEPTH));
    assign tx_push      = wr_txdata && !tx_full;
    assign tx_ovf       = wr_txdata && tx_full && !tx_clear;
    assign eng_tx_valid = (tx_cnt != '0);
    assign tx_pop       = eng_tx_valid && eng_tx_ready;

    xfc_word_fifo #(.W(REG_DW), .DEPTH(DEPTH)) u_tx_q (
        .clk(clk), .rst(rst), .clear(tx_clear),
        .push(tx_push), .push_data(reg_wdata),
        .pop(tx_pop), .head(eng_tx_data), .count(tx_cnt)
    );

    // receive path: engine pushes, software pops
    assign rx_full      = (rx_cnt == CW'(DEPTH));
    assign eng_rx_ready = !rx_full && !rx_clear;
    assign rx_push      = eng_rx_valid && eng_rx_ready;
    assign rx_pop       = rd_rxdata && (rx_cnt != '0);
    assign rx_unf       = rd_rxdata && (rx_cnt == '0);

    xfc_word_fifo #(.W(REG_DW), .DEPTH(DEPTH)) u_rx_q (
        .clk(clk), .rst(rst), .clear(rx_clear),
        .push(rx_push), .push_data(eng_rx_data),
        .pop(rx_pop), .head(rx_head), .count(rx_cnt)
    );

    assign tx_free = CW'(DEPTH) - tx_cnt;
    assign tx_req  = CMP_W'(tx_free) > CMP_W'(tx_trig);
    assign rx_req  = CMP_W'(rx_cnt)  > CMP_W'(rx_trig);

    assign ev_set.pkt   = ev_pkt_done;
    assign ev_set.all   = ev_all_done;
    assign ev_set.txovf = tx_ovf;
    assign ev_set.rxunf = rx_unf;
    assign ev_set.nack  = ev_nack;
    assign ev_set.arb   = ev_arb_lost;

    xfc_irq_regs #(.PKT_FORCE(PKT_IRQ_FORCE)) u_irq (
        .clk(clk), .rst(rst),
        .ev_set(ev_set), .live_req({tx_req, rx_req}),
        .clr_we(wr_istat), .clr_bits(evt_t'(reg_wdata[7:2])),
        .mask_we(wr_imask), .mask_wdata(reg_wdata[7:0]),
        .status(istat), .mask(imask), .irq(irq)
    );

    always_comb begin
        case (reg_addr)
            A_RXDATA: reg_rdata = (rx_cnt != '0) ? rx_head : '0;
            A_FCTRL:  reg_rdata = zext8({tx_trig, rx_trig, tx_busy, rx_busy});
            A_FSTAT:  reg_rdata = zext8({OCC_W'(tx_free), OCC_W'(rx_cnt)});
            A_IMASK:  reg_rdata = zext8(imask);
            A_ISTAT:  reg_rdata = zext8(istat);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/xfer_fifo_ctrl_chk.sv
module xfer_fifo_ctrl_chk import xfc_pkg::*; #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       reg_wr,
    input logic                       reg_rd,
    input logic [REG_AW-1:0]          reg_addr,
    input logic                       flush_tx_bit,
    input logic                       eng_tx_valid,
    input logic                       eng_tx_ready,
    input logic [REG_DW-1:0]          eng_tx_data,
    input logic                       eng_rx_ready,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic                       tx_busy,
    input logic [7:0]                 istat
);
    localparam int CW = $clog2(DEPTH+1);

    logic tx_flush_wr;
    assign tx_flush_wr = reg_wr && (reg_addr == A_FCTRL) && flush_tx_bit;

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (rst)
        tx_flush_wr |=> (tx_cnt == '0));

    assert_flush_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> $past(tx_busy, 2));

    assert_overflow_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_TXDATA && tx_cnt == CW'(DEPTH)) |=> istat[5]);

    assert_underflow_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_RXDATA && rx_cnt == '0) |=> istat[4]);

    assert_tx_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (eng_tx_valid && !eng_tx_ready && !tx_flush_wr) |=> (eng_tx_valid && $stable(eng_tx_data)));

    assert_rx_full_block_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt == CW'(DEPTH)) |-> !eng_rx_ready);
endmodule

bind xfer_fifo_ctrl xfer_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .flush_tx_bit(reg_wdata[1]), .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
    .eng_tx_data(eng_tx_data), .eng_rx_ready(eng_rx_ready), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_busy(tx_busy), .istat(istat)
);

// File: tb/xfer_fifo_ctrl_bench.sv
module xfer_fifo_ctrl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_tx_valid, eng_tx_ready = 1'b0;
    logic [31:0] eng_tx_data;
    logic        eng_rx_valid = 1'b0, eng_rx_ready;
    logic [31:0] eng_rx_data = '0;
    logic        ev_pkt_done = 1'b0, ev_all_done = 1'b0, ev_nack = 1'b0, ev_arb_lost = 1'b0;
    logic        irq;
    logic [31:0] rdata_f, txd_f;
    logic        txv_f, rxr_f, irq_f;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xfer_fifo_ctrl #(.DEPTH(D), .PKT_IRQ_FORCE(1'b0)) u_xfer_fifo_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data),
        .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready), .eng_rx_data(eng_rx_data),
        .ev_pkt_done(ev_pkt_done), .ev_all_done(ev_all_done), .ev_nack(ev_nack),
        .ev_arb_lost(ev_arb_lost), .irq(irq)
    );

    xfer_fifo_ctrl #(.DEPTH(D), .PKT_IRQ_FORCE(1'b1)) u_forced (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_f),
        .eng_tx_valid(txv_f), .eng_tx_ready(eng_tx_ready), .eng_tx_data(txd_f),
        .eng_rx_valid(eng_rx_valid), .eng_rx_ready(rxr_f), .eng_rx_data(eng_rx_data),
        .ev_pkt_done(ev_pkt_done), .ev_all_done(ev_all_done), .ev_nack(ev_nack),
        .ev_arb_lost(ev_arb_lost), .irq(irq_f)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic eng_pop(output logic vld, output logic [31:0] d);
        eng_tx_ready = 1'b1;
        #1 vld = eng_tx_valid; d = eng_tx_data;
        @(negedge clk);
        eng_tx_ready = 1'b0;
    endtask

    task automatic eng_push(input logic [31:0] d, output logic rdy);
        eng_rx_valid = 1'b1; eng_rx_data = d;
        #1 rdy = eng_rx_ready;
        @(negedge clk);
        eng_rx_valid = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, d;
        logic vld, rdy;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(8'h60, v); check("R1", "status", v, 32'h80);
        reg_read(8'h5C, v); check("R1", "control", v, 32'h0);
        reg_read(8'h64, v); check("R1", "enable", v, 32'h0);
        reg_read(8'h68, v); check("R1", "int status", v, 32'h02);
        check("R1", "irq", 32'(irq), 32'h0);
        check("R1", "tx valid", 32'(eng_tx_valid), 32'h0);

        // R2 ordering through the engine port
        for (int i = 0; i < 5; i++) reg_write(8'h50, 32'h1000 + i);
        reg_read(8'h60, v); check("R2", "free after 5", v, 32'h30);
        for (int i = 0; i < 5; i++) begin
            eng_pop(vld, d);
            check("R2", "tx valid", 32'(vld), 32'h1);
            check("R2", "tx order", d, 32'h1000 + i);
        end
        #1 check("R2", "tx valid empty", 32'(eng_tx_valid), 32'h0);
        @(negedge clk);

        // R7 transmit threshold sweep over all levels and fills
        for (int t = 0; t < 8; t++) begin
            reg_write(8'h5C, (t << 5) | 2);
            repeat (2) @(negedge clk);
            for (int n = 0; n <= D; n++) begin
                reg_read(8'h68, v);
                check("R7", "tx request", 32'(v[1]), 32'((D - n) > t));
                reg_read(8'h60, v);
                check("R2", "tx free field", 32'(v[7:4]), 32'(D - n));
                if (n < D) reg_write(8'h50, 32'hA000 + n);
            end
        end

        // R3 overflow on a full transmit queue
        reg_write(8'h50, 32'hDEAD);
        reg_read(8'h68, v); check("R3", "overflow bit", 32'(v[5]), 32'h1);
        reg_read(8'h60, v); check("R3", "still full", v, 32'h00);
        for (int k = 0; k < D; k++) begin
            eng_pop(vld, d);
            check("R3", "kept word", d, 32'hA000 + k);
        end
        #1 check("R3", "no extra word", 32'(eng_tx_valid), 32'h0);
        @(negedge clk);

        // R4/R7 receive threshold sweep
        for (int t = 0; t < 8; t++) begin
            reg_write(8'h5C, (t << 2) | 1);
            repeat (2) @(negedge clk);
            for (int n = 0; n <= D; n++) begin
                reg_read(8'h68, v);
                check("R7", "rx request", 32'(v[0]), 32'(n > t));
                reg_read(8'h60, v);
                check("R4", "rx count", v, 32'h80 | n);
                if (n < D) begin
                    eng_push(32'hB000 + n, rdy);
                    check("R4", "rx ready", 32'(rdy), 32'h1);
                end else begin
                    #1 check("R4", "rx ready full", 32'(eng_rx_ready), 32'h0);
                    @(negedge clk);
                end
            end
        end
        for (int k = 0; k < D; k++) begin
            reg_read(8'h54, v);
            check("R4", "rx order", v, 32'hB000 + k);
        end

        // R5 underflow
        reg_read(8'h54, v); check("R5", "empty read", v, 32'h0);
        reg_read(8'h68, v); check("R5", "underflow bit", v, 32'h32);

        // R9 write back what was read
        reg_write(8'h68, v);
        reg_read(8'h68, v); check("R9", "write back", v, 32'h02);

        // R8 events
        ev_pkt_done = 1'b1; @(negedge clk); ev_pkt_done = 1'b0;
        reg_read(8'h68, v); check("R8", "pkt", v, 32'h82);
        ev_all_done = 1'b1; @(negedge clk); ev_all_done = 1'b0;
        reg_read(8'h68, v); check("R8", "all", v, 32'hC2);
        ev_nack = 1'b1; @(negedge clk); ev_nack = 1'b0;
        reg_read(8'h68, v); check("R8", "nack", v, 32'hCA);
        ev_arb_lost = 1'b1; @(negedge clk); ev_arb_lost = 1'b0;
        reg_read(8'h68, v); check("R8", "arb", v, 32'hCE);

        // R9 partial clear and set-wins
        reg_write(8'h68, 32'h40);
        reg_read(8'h68, v); check("R9", "partial clear", v, 32'h8E);
        ev_nack = 1'b1; reg_write(8'h68, 32'h08); ev_nack = 1'b0;
        reg_read(8'h68, v); check("R9", "set wins", v, 32'h8E);

        // R10 enable gating, R11 forced packet bit
        #1 check("R10", "irq masked", 32'(irq), 32'h0);
        check("R11", "forced irq", 32'(irq_f), 32'h1);
        @(negedge clk);
        reg_write(8'h64, 32'h08); #1 check("R10", "irq nack", 32'(irq), 32'h1); @(negedge clk);
        reg_write(8'h64, 32'h80); #1 check("R10", "irq pkt", 32'(irq), 32'h1); @(negedge clk);
        reg_write(8'h64, 32'h00);
        reg_write(8'h68, 32'hFC);
        reg_read(8'h68, v); check("R9", "clear all", v, 32'h02);
        #1 check("R11", "forced idle", 32'(irq_f), 32'h0); @(negedge clk);
        reg_write(8'h64, 32'h02); #1 check("R10", "irq tx req", 32'(irq), 32'h1); @(negedge clk);
        reg_write(8'h64, 32'h01); #1 check("R10", "irq rx idle", 32'(irq), 32'h0); @(negedge clk);
        reg_write(8'h64, 32'h00);

        // R6 transmit flush
        for (int i = 0; i < 3; i++) reg_write(8'h50, 32'hC000 + i);
        reg_read(8'h60, v); check("R6", "pre flush", v, 32'h50);
        reg_write(8'h5C, 32'hE2);
        reg_read(8'h5C, v); check("R6", "tx flush busy 1", v, 32'hE2);
        reg_read(8'h5C, v); check("R6", "tx flush busy 2", v, 32'hE2);
        reg_read(8'h5C, v); check("R6", "tx flush done", v, 32'hE0);
        reg_read(8'h60, v); check("R6", "tx emptied", v, 32'h80);
        #1 check("R6", "tx valid", 32'(eng_tx_valid), 32'h0); @(negedge clk);

        // R6 receive flush
        eng_push(32'hD000, rdy);
        eng_push(32'hD001, rdy);
        reg_read(8'h60, v); check("R6", "rx pre flush", v, 32'h82);
        reg_write(8'h5C, 32'h1D);
        #1 check("R6", "rx ready in flush", 32'(eng_rx_ready), 32'h0); @(negedge clk);
        reg_read(8'h5C, v); check("R6", "rx flush busy", v, 32'h1D);
        reg_read(8'h5C, v); check("R6", "rx flush done", v, 32'h1C);
        reg_read(8'h60, v); check("R6", "rx emptied", v, 32'h80);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule